// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block sits between on-chip logic and an external 256-word by 16-bit serial EEPROM. The device uses a chip select, a serial clock and one data line in each direction. A client hands the controller one operation at a time: read, write, erase, erase/write enable or erase/write disable, with an 8-bit word address and, for writes, a 16-bit data word. The controller turns the operation into a framed bit sequence. It clocks the sequence out on a divided serial clock and collects any returned word. When the operation is over it raises a one-cycle response that carries the read data and an error flag.

The command side is a valid/ready port. A command is taken in the cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` then stays low, and `busy` stays high, until the response cycle. A client that is held off simply keeps waiting, and a request raised while the controller is busy has no effect. The response is a bare one-cycle pulse with no back-pressure, so the client must be able to take it. After a write or erase, the controller waits out the device's self-timed programming cycle by polling its ready line. With `auto_protect` set, it also wraps each write or erase in an enable frame before and a disable frame after, so the array is write-protected again when the command ends.

Top module: `mw_eeprom_host`

## Requirements
- R1: While `rst_n` is low and right after it, `ee_cs`, `ee_sck` and `rsp_valid` are low, `cmd_ready` is high and `busy` is low.
- R2: A command is taken only when `cmd_valid` and `cmd_ready` are high together. In the next cycle `cmd_ready` is low and `busy` is high, and both stay that way until the response cycle. A request made while the controller is busy is ignored and causes no frame.
- R3: The `cmd_op` codes are 0 read, 1 write, 2 erase, 3 enable and 4 disable. Each frame raises `ee_cs` and sends a start bit of 1, then a 2-bit opcode, then 8 address bits MSB first. The opcodes are read 10, write 01, erase 11, enable 00 and disable 00. Enable carries address 11000000 and disable carries address 00000000. A write frame then adds 16 data bits MSB first, for 27 bits in all. Enable, disable and erase frames are 11 bits.
- R4: `ee_sck` is low whenever `ee_cs` is low. Each serial bit lasts 2*HALF_DIV system clocks: HALF_DIV low, then HALF_DIV high. `ee_dout` does not change while `ee_sck` is high.
- R5: A read frame gives 17 more clocks after the address. The bit sampled on the first of them is dropped, and the next 16 bits, MSB first, appear on `rsp_rdata` in the response cycle.
- R6: After a write or erase frame, `ee_cs` is held low and then raised without clocks. `ee_din` is then sampled every system clock until it reads 1. The response comes only after the device reports ready, and no frame is sent while the device is programming.
- R7: If `ee_din` has not read 1 within POLL_MAX samples, polling stops. The command ends with `rsp_err` high, and no further frame is sent for that command.
- R8: With `auto_protect` high at acceptance, a write or erase is sent as three frames: enable, the operation with its poll, then disable. With it low, only the operation frame is sent. Reads, enables and disables always send one frame.
- R9: Between any two chip-select high periods, `ee_cs` is low for at least 2*HALF_DIV system clocks.
- R10: A `cmd_op` of 5, 6 or 7 leaves `ee_cs` low. It is answered within three cycles with `rsp_err` high.
- R11: Each accepted command produces exactly one response, and `rsp_valid` is high for a single cycle. `rsp_err` is low unless R7 or R10 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_op | input | 3 | Operation code (R3) |
| cmd_addr | input | 8 | Word address |
| cmd_wdata | input | 16 | Write data |
| auto_protect | input | 1 | Wrap modify commands in enable/disable frames |
| busy | output | 1 | A command is in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Word returned by a read |
| rsp_err | output | 1 | Poll timeout or unsupported operation |
| ee_cs | output | 1 | Device chip select |
| ee_sck | output | 1 | Serial clock, idle low |
| ee_dout | output | 1 | Serial data to the device |
| ee_din | input | 1 | Serial data and ready status from the device |

## Verification
A sequencer that takes a wrong branch shows up at the device pins within one frame. The count, opcodes or addresses of the frames seen for one command will be wrong: a missing disable frame, or a poll that never happens. A bit counter or phase counter that is off by one changes the frame length. It also shifts returned words by one bit, which shows in the very next read. A poll that ends too early lets the response, or the next frame, arrive while the device model is still programming. A hold-off fault lets a request made mid-command alter a word that is read back later.

// File: rtl/mw_pkg.sv
package mw_pkg;
  // Client operation codes on cmd_op
  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_WRITE = 3'd1;
  localparam logic [2:0] OP_ERASE = 3'd2;
  localparam logic [2:0] OP_WREN  = 3'd3;
  localparam logic [2:0] OP_WRDIS = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE, S_FRAME, S_GAP, S_POLL, S_RESP
  } seq_state_e;

  typedef enum logic [1:0] {
    STEP_EN, STEP_MAIN, STEP_DIS
  } seq_step_e;
endpackage

// File: rtl/mw_frame.sv
// Serial bit engine: shifts a left-aligned frame out MSB first and
// samples the return line at the end of every high phase.
module mw_frame #(
  parameter int FW       = 28,
  parameter int DW       = 16,
  parameter int HALF_DIV = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [FW-1:0]               tx_bits,
  input  logic [$clog2(FW+1)-1:0]     nbits,
  input  logic                        din,
  output logic                        sck,
  output logic                        dout,
  output logic [DW-1:0]               rx_word,
  output logic                        done
);
  localparam int CW = $clog2(FW + 1);
  localparam int PW = (2 * HALF_DIV > 2) ? $clog2(2 * HALF_DIV) : 1;
  localparam logic [PW-1:0] PH_HI   = PW'(HALF_DIV);
  localparam logic [PW-1:0] PH_LAST = PW'(2 * HALF_DIV - 1);

  logic          active;
  logic [PW-1:0] ph;
  logic [CW-1:0] left;
  logic [FW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      ph      <= '0;
      left    <= '0;
      sh      <= '0;
      rx_word <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        ph     <= '0;
        left   <= nbits;
        sh     <= tx_bits;
      end else if (active) begin
        if (ph == PH_LAST) begin
          ph      <= '0;
          sh      <= {sh[FW-2:0], 1'b0};
          rx_word <= {rx_word[DW-2:0], din};
          left    <= left - 1'b1;
          if (left == CW'(1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  assign sck  = active && (ph >= PH_HI);
  assign dout = active && sh[FW-1];
endmodule

// File: rtl/mw_poll.sv
// Ready poller: samples the status line every cycle after start until it
// reads 1 or POLL_MAX samples have been taken.
module mw_poll #(
  parameter int POLL_MAX = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic din,
  output logic ok,
  output logic tmo
);
  localparam int TW = $clog2(POLL_MAX + 1);

  logic          on;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on  <= 1'b0;
      cnt <= '0;
      ok  <= 1'b0;
      tmo <= 1'b0;
    end else begin
      ok  <= 1'b0;
      tmo <= 1'b0;
      if (start) begin
        on  <= 1'b1;
        cnt <= '0;
      end else if (on) begin
        if (din) begin
          on <= 1'b0;
          ok <= 1'b1;
        end else if (cnt == TW'(POLL_MAX - 1)) begin
          on  <= 1'b0;
          tmo <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mw_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int HALF_DIV = 2,
  parameter int POLL_MAX = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          auto_protect,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          ee_cs,
  output logic          ee_sck,
  output logic          ee_dout,
  input  logic          ee_din
);
  localparam int FW  = 4 + AW + DW;          // start+opcode+addr+data+read pad
  localparam int CW  = $clog2(FW + 1);
  localparam int GAP = 2 * HALF_DIV;
  localparam int GW  = $clog2(GAP + 1);

  seq_state_e    state;
  seq_step_e     step;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          auto_q, polled, err_q;
  logic [GW-1:0] gap_cnt;
  logic          fr_start, fr_done, poll_start, poll_ok, poll_tmo;
  logic [FW-1:0] fr_tx;
  logic [CW-1:0] fr_n;
  logic [DW-1:0] fr_rx;

  function automatic logic [FW-1:0] frame_bits(input logic [2:0] op,
                                               input logic [AW-1:0] a,
                                               input logic [DW-1:0] d);
    logic [1:0]    opc;
    logic [AW-1:0] fa;
    logic [DW-1:0] fd;
    fa = a;
    fd = '0;
    case (op)
      OP_READ:  opc = 2'b10;
      OP_WRITE: begin opc = 2'b01; fd = d; end
      OP_ERASE: opc = 2'b11;
      OP_WREN:  begin opc = 2'b00; fa = {2'b11, {(AW-2){1'b0}}}; end
      default:  begin opc = 2'b00; fa = '0; end
    endcase
    return {1'b1, opc, fa, fd, 1'b0};
  endfunction

  function automatic logic [CW-1:0] frame_len(input logic [2:0] op);
    case (op)
      OP_READ:  return CW'(FW);
      OP_WRITE: return CW'(FW - 1);
      default:  return CW'(3 + AW);
    endcase
  endfunction

  wire is_mod = (op_q == OP_WRITE) || (op_q == OP_ERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      step       <= STEP_MAIN;
      op_q       <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      auto_q     <= 1'b0;
      polled     <= 1'b0;
      err_q      <= 1'b0;
      gap_cnt    <= '0;
      fr_start   <= 1'b0;
      fr_tx      <= '0;
      fr_n       <= '0;
      poll_start <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_err    <= 1'b0;
    end else begin
      fr_start   <= 1'b0;
      poll_start <= 1'b0;
      rsp_valid  <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          op_q    <= cmd_op;
          addr_q  <= cmd_addr;
          wdata_q <= cmd_wdata;
          auto_q  <= auto_protect;
          polled  <= 1'b0;
          err_q   <= 1'b0;
          if (cmd_op > OP_WRDIS) begin
            err_q <= 1'b1;
            state <= S_RESP;
          end else if (auto_protect && (cmd_op == OP_WRITE || cmd_op == OP_ERASE)) begin
            step     <= STEP_EN;
            fr_tx    <= frame_bits(OP_WREN, '0, '0);
            fr_n     <= frame_len(OP_WREN);
            fr_start <= 1'b1;
            state    <= S_FRAME;
          end else begin
            step     <= STEP_MAIN;
            fr_tx    <= frame_bits(cmd_op, cmd_addr, cmd_wdata);
            fr_n     <= frame_len(cmd_op);
            fr_start <= 1'b1;
            state    <= S_FRAME;
          end
        end
        S_FRAME: if (fr_done) begin
          gap_cnt <= '0;
          state   <= S_GAP;
        end
        S_GAP: begin
          if (gap_cnt == GW'(GAP - 1)) begin
            if (step == STEP_EN) begin
              step     <= STEP_MAIN;
              fr_tx    <= frame_bits(op_q, addr_q, wdata_q);
              fr_n     <= frame_len(op_q);
              fr_start <= 1'b1;
              state    <= S_FRAME;
            end else if (step == STEP_MAIN && is_mod && !polled) begin
              poll_start <= 1'b1;
              state      <= S_POLL;
            end else if (step == STEP_MAIN && is_mod && auto_q && !err_q) begin
              step     <= STEP_DIS;
              fr_tx    <= frame_bits(OP_WRDIS, '0, '0);
              fr_n     <= frame_len(OP_WRDIS);
              fr_start <= 1'b1;
              state    <= S_FRAME;
            end else begin
              state <= S_RESP;
            end
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        S_POLL: if (poll_ok || poll_tmo) begin
          polled  <= 1'b1;
          err_q   <= err_q | poll_tmo;
          gap_cnt <= '0;
          state   <= S_GAP;
        end
        S_RESP: begin
          rsp_valid <= 1'b1;
          rsp_err   <= err_q;
          rsp_rdata <= (op_q == OP_READ) ? fr_rx : '0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == S_IDLE);
  assign busy      = !cmd_ready;
  assign ee_cs     = (state == S_FRAME) || (state == S_POLL);

  mw_frame #(.FW(FW), .DW(DW), .HALF_DIV(HALF_DIV)) u_frame (
    .clk(clk), .rst_n(rst_n), .start(fr_start), .tx_bits(fr_tx), .nbits(fr_n),
    .din(ee_din), .sck(ee_sck), .dout(ee_dout), .rx_word(fr_rx), .done(fr_done)
  );

  mw_poll #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk(clk), .rst_n(rst_n), .start(poll_start), .din(ee_din),
    .ok(poll_ok), .tmo(poll_tmo)
  );
endmodule

// File: rtl/mw_eeprom_host_chk.sv
module mw_eeprom_host_chk #(
  parameter int HALF_DIV = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic       busy,
  input logic       rsp_valid,
  input logic       ee_cs,
  input logic       ee_sck,
  input logic       ee_dout
);
  localparam int GAP = 2 * HALF_DIV;

  // cycles with chip select low, saturating; starts saturated
  logic [15:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt <= 16'hFFFF;
    else if (ee_cs)    low_cnt <= '0;
    else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
  end

  a_r4_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sck);
  a_r4_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sck && $past(ee_sck)) |-> $stable(ee_dout));
  a_r2_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));
  a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (low_cnt >= 16'(GAP)));
  a_r10_bad_op_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op > 3'd4) |=> !ee_cs);
  a_r6_rsp_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !ee_cs);
endmodule

bind mw_eeprom_host mw_eeprom_host_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .busy(busy), .rsp_valid(rsp_valid), .ee_cs(ee_cs),
  .ee_sck(ee_sck), .ee_dout(ee_dout)
);

// File: tb/mw_eeprom_host_bench.sv
module mw_eeprom_host_bench;
  localparam int HALF = 2;
  localparam int PMAX = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [7:0]  cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        auto_protect = 1'b0;
  logic        busy, rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic        ee_cs, ee_sck, ee_dout;
  logic        ee_din = 1'b0;

  always #5 clk = ~clk;

  mw_eeprom_host #(.HALF_DIV(HALF), .POLL_MAX(PMAX)) u_mw_eeprom_host (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .auto_protect(auto_protect), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .ee_cs(ee_cs), .ee_sck(ee_sck),
    .ee_dout(ee_dout), .ee_din(ee_din)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input int i);
    return 16'(i * 16'h0101) ^ 16'h5A3C;
  endfunction

  // ---------------- device model ----------------
  logic [15:0] dmem [256];
  logic [15:0] expm [256];
  int   dev_busy = 0, busy_time = 60;
  bit   we_en = 0;
  int   rises = 0, pend = 0, min_gap = 1000, cs_low_run = 1000;
  int   sdo_viol = 0, sck_viol = 0, busy_viol = 0, hi_bad = 0, hi_run = 0;
  int   fr_total = 0, poll_cnt = 0;
  logic [1:0]  lg_opc [64];
  logic [7:0]  lg_addr [64];
  int          lg_len [64];
  logic [31:0] sh = '0;
  logic [1:0]  cur_opc = '0;
  logic [7:0]  cur_addr = '0;
  logic [15:0] pd = '0, rd_word = '0;
  bit   reading = 0, prev_sck = 0, prev_cs = 0, sdo_rise = 0;

  initial begin
    for (int i = 0; i < 256; i++) begin dmem[i] = init_word(i); expm[i] = init_word(i); end
    forever begin
      @(negedge clk);
      if (dev_busy > 0) dev_busy--;
      if (!ee_cs) begin
        if (ee_sck) sck_viol++;
        if (prev_cs) begin
          if (rises > 0) begin
            lg_opc[fr_total % 64] = cur_opc; lg_addr[fr_total % 64] = cur_addr;
            lg_len[fr_total % 64] = rises; fr_total++;
          end else poll_cnt++;
          if (pend == 1 && we_en) begin dmem[cur_addr] = pd; dev_busy = busy_time; end
          if (pend == 2 && we_en) begin dmem[cur_addr] = 16'hFFFF; dev_busy = busy_time; end
          pend = 0; rises = 0; reading = 0; cs_low_run = 0;
        end
        cs_low_run++;
        ee_din = 1'b0;
      end else begin
        if (!prev_cs && cs_low_run < min_gap) min_gap = cs_low_run;
        if (ee_sck && !prev_sck) begin
          rises++;
          if (rises == 1 && dev_busy > 0) busy_viol++;
          sh = {sh[30:0], ee_dout};
          sdo_rise = ee_dout;
          if (rises == 11) begin
            cur_opc = sh[9:8]; cur_addr = sh[7:0];
            if (cur_opc == 2'b10) begin reading = 1; rd_word = dmem[cur_addr]; end
            if (cur_opc == 2'b00 && cur_addr[7:6] == 2'b11) we_en = 1;
            if (cur_opc == 2'b00 && cur_addr[7:6] == 2'b00) we_en = 0;
            if (cur_opc == 2'b11) pend = 2;
          end
          if (cur_opc == 2'b01 && rises == 27) begin pend = 1; pd = sh[15:0]; end
          if (reading && rises >= 12 && rises <= 28)
            ee_din = (rises == 12) ? 1'b0 : rd_word[28 - rises];
        end
        if (ee_sck && prev_sck && ee_dout != sdo_rise) sdo_viol++;
        if (rises == 0) ee_din = (dev_busy == 0);
      end
      if (ee_sck) hi_run++;
      else begin
        if (hi_run != 0 && hi_run != HALF) hi_bad++;
        hi_run = 0;
      end
      prev_sck = ee_sck; prev_cs = ee_cs;
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [15:0] r_data;
  logic        r_err;

  task automatic wait_rsp();
    int lim = 0;
    while (!rsp_valid && lim < 20000) begin @(negedge clk); lim++; end
    r_data = rsp_rdata; r_err = rsp_err;
    @(negedge clk);
    chk("R11 pulse width", {31'd0, rsp_valid}, 0);
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [7:0] a,
                        input logic [15:0] d, input bit ap);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d; auto_protect = ap;
    @(negedge clk);
    cmd_valid = 0;
    chk("R2 ready low after accept", {31'd0, cmd_ready}, 0);
    wait_rsp();
  endtask

  int f0, p0;

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 cs", {31'd0, ee_cs}, 0);
    chk("R1 sck", {31'd0, ee_sck}, 0);
    chk("R1 ready", {31'd0, cmd_ready}, 1);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 rsp", {31'd0, rsp_valid}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R5: plain read
    f0 = fr_total;
    do_cmd(3'd0, 8'd5, 16'h0, 0);
    chk("R5 read data", r_data, expm[5]);
    chk("R3 read opcode", lg_opc[f0 % 64], 2'b10);
    chk("R3 read addr", lg_addr[f0 % 64], 8'd5);
    chk("R5 read clocks", lg_len[f0 % 64], 28);
    chk("R11 err clear", r_err, 0);

    // R8 auto off while protected: only one frame, write does not land
    f0 = fr_total; p0 = poll_cnt;
    do_cmd(3'd1, 8'd7, 16'h1234, 0);
    chk("R8 one frame without auto", fr_total - f0, 1);
    chk("R6 one poll", poll_cnt - p0, 1);
    chk("R3 write length", lg_len[f0 % 64], 27);
    do_cmd(3'd0, 8'd7, 16'h0, 0);
    chk("R8 protected write no effect", r_data, expm[7]);

    // R3 explicit enable, write, disable
    f0 = fr_total;
    do_cmd(3'd3, 8'h00, 16'h0, 0);
    chk("R3 enable opcode", lg_opc[f0 % 64], 2'b00);
    chk("R3 enable addr", lg_addr[f0 % 64], 8'hC0);
    chk("R3 enable length", lg_len[f0 % 64], 11);
    do_cmd(3'd1, 8'd7, 16'hBEEF, 0);
    expm[7] = 16'hBEEF;
    chk("R6 response after ready", dev_busy, 0);
    f0 = fr_total;
    do_cmd(3'd4, 8'h55, 16'h0, 0);
    chk("R3 disable addr", lg_addr[f0 % 64], 8'h00);
    do_cmd(3'd0, 8'd7, 16'h0, 0);
    chk("R3 write data lands", r_data, 16'hBEEF);

    // random traffic with auto protection
    for (int k = 0; k < 30; k++) begin
      logic [2:0] op; logic [7:0] a; logic [15:0] d;
      op = 3'($urandom % 3); a = 8'($urandom); d = 16'($urandom);
      if (k == 0) a = 8'hFF;
      if (k == 1) begin a = 8'h00; d = 16'h0000; op = 3'd1; end
      f0 = fr_total;
      do_cmd(op, a, d, 1);
      chk("R11 no error", r_err, 0);
      if (op == 3'd0) begin
        chk("R5 random read", r_data, expm[a]);
        chk("R8 read one frame", fr_total - f0, 1);
      end else begin
        expm[a] = (op == 3'd1) ? d : 16'hFFFF;
        chk("R8 three frames", fr_total - f0, 3);
        chk("R8 enable first", lg_addr[f0 % 64], 8'hC0);
        chk("R8 disable last", {lg_opc[(f0 + 2) % 64], lg_addr[(f0 + 2) % 64]}, 10'h000);
        chk("R8 protection restored", {31'd0, we_en}, 0);
        chk("R6 done after ready", dev_busy, 0);
      end
    end
    do_cmd(3'd0, 8'h00, 16'h0, 0);
    chk("R5 read zero word", r_data, expm[0]);

    // R2 request while busy is ignored
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd0; cmd_addr = 8'd20; auto_protect = 0;
    @(negedge clk);
    cmd_valid = 0;
    repeat (6) @(negedge clk);
    chk("R2 busy during read", {31'd0, busy}, 1);
    cmd_valid = 1; cmd_op = 3'd1; cmd_addr = 8'd21; cmd_wdata = 16'h0F0F; auto_protect = 1;
    @(negedge clk);
    cmd_valid = 0;
    wait_rsp();
    chk("R5 read under ignored request", r_data, expm[20]);
    repeat (20) @(negedge clk);
    chk("R2 no second response", {31'd0, rsp_valid}, 0);
    do_cmd(3'd0, 8'd21, 16'h0, 0);
    chk("R2 ignored write had no effect", r_data, expm[21]);

    // R10 unsupported op
    f0 = fr_total;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd6;
    @(negedge clk);
    cmd_valid = 0;
    for (int w = 0; w < 3 && !rsp_valid; w++) @(negedge clk);
    chk("R10 quick response", {31'd0, rsp_valid}, 1);
    chk("R10 error flag", {31'd0, rsp_err}, 1);
    chk("R10 no frame", fr_total - f0, 0);
    chk("R10 cs low", {31'd0, ee_cs}, 0);

    // R7 poll timeout
    busy_time = 2000;
    f0 = fr_total;
    do_cmd(3'd2, 8'd30, 16'h0, 1);
    expm[30] = 16'hFFFF;
    chk("R7 timeout error", r_err, 1);
    chk("R7 no frame after timeout", fr_total - f0, 2);
    busy_time = 60;
    repeat (2100) @(negedge clk);
    do_cmd(3'd0, 8'd30, 16'h0, 1);
    chk("R7 erase landed", r_data, 16'hFFFF);

    chk("R4 dout stable while sck high", sdo_viol, 0);
    chk("R4 sck low while cs low", sck_viol, 0);
    chk("R4 high phase length", hi_bad, 0);
    chk("R9 min cs low gap", {31'd0, min_gap >= 2 * HALF}, 1);
    chk("R6 no frame while programming", busy_viol, 0);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule